// File: doc/BRIEF.md
# Wrapping Page Write Buffer

This block gathers the data bytes of a single page-write transaction from a serial memory front end and holds them in a 16-byte page buffer until the transaction ends. A transaction opens with a start pulse carrying the word address. Each later byte strobe stores one byte at the current column. The column then advances and wraps from 15 back to 0, while the page number stays fixed. Any number of bytes may arrive. A later byte that lands on an already loaded column replaces the earlier one.

The transaction closes in one of two ways. A commit pulse marks a stop on a byte boundary. An abort pulse marks a stop in the middle of a byte. A commit after at least one complete byte makes the block sweep the page in ascending column order and emit one memory write per loaded column. At the end it raises a done pulse and presents the final column pointer, so the caller can update its shared current-address counter. An abort, or a commit with no bytes loaded, discards everything and leaves memory untouched.

Top module: `pgwr_buf`

## Requirements
- R1: After reset, busy, done and mem_we are low. A start pulse while not busy opens a transaction: the page is start_addr[7:4], the column is start_addr[3:0], and every per-column loaded flag is cleared.
- R2: Each byte_vld pulse during a transaction stores byte_data at the current column. The column then increments modulo 16 (15 goes to 0), and the page never changes.
- R3: The number of bytes is not limited. A byte that arrives at a column already loaded in the same transaction replaces the earlier value.
- R4: At the done pulse, final_addr equals {page, (start column + byte count) mod 16}. For example, 12 bytes from column 10 leave column 6.
- R5: An abort pulse, or a commit pulse with no byte loaded, ends the transaction with no memory write, no busy and no done.
- R6: A commit pulse after at least one byte writes every loaded column exactly once and no other column. The writes go to mem_addr = {page, column} with the last stored value, in ascending column order.
- R7: busy is high for exactly 16 cycles, starting the cycle after the commit. done is a one-cycle pulse in the cycle busy falls.
- R8: While busy is high, start, byte_vld, abort and commit have no effect on the memory writes or on final_addr.
- R9: A start pulse during an open transaction discards the bytes loaded so far and opens a new transaction at the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a transaction at start_addr |
| start_addr | input | 8 | Starting word address {page, column} |
| byte_vld | input | 1 | One complete, acknowledged data byte |
| byte_data | input | 8 | Data byte qualified by byte_vld |
| abort | input | 1 | Stop in the middle of a byte: discard |
| commit | input | 1 | Stop on a byte boundary: write the loaded bytes |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 8 | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| busy | output | 1 | Commit sweep in progress |
| done | output | 1 | One-cycle pulse at the end of the sweep |
| final_addr | output | 8 | Column pointer after the transaction, valid at done |

## Verification
Several internal faults show up at the memory port within one commit sweep. A wrong column counter or page register puts data at the wrong address or in the wrong wrap position. A stale loaded flag writes a column the transaction never touched. A missed overwrite leaves an older byte in memory. A sweep-counter fault shows up at the done pulse as a busy window longer or shorter than 16 cycles, or as a wrong final_addr. The bench sweeps every start column against byte counts from 0 to 20 under both endings and compares a shadow memory with the arithmetic expectation after each transaction.

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int ADDR_W = 8,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              abort,
  input  logic              commit,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] final_addr
);
  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int DEPTH  = 1 << COL_W;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_FLUSH} st_t;

  st_t               st;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q, scan_q;
  logic [DEPTH-1:0]  dirty_q;
  logic [DATA_W-1:0] data_q [DEPTH];
  logic              has_data, done_q;
  logic [ADDR_W-1:0] fin_q;

  wire in_load = (st == S_LOAD);
  wire accept  = in_load && byte_vld && !abort && !commit && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      page_q   <= '0;
      col_q    <= '0;
      scan_q   <= '0;
      dirty_q  <= '0;
      has_data <= 1'b0;
      done_q   <= 1'b0;
      fin_q    <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st       <= S_LOAD;
          page_q   <= start_addr[ADDR_W-1:COL_W];
          col_q    <= start_addr[COL_W-1:0];
          dirty_q  <= '0;
          has_data <= 1'b0;
        end
        S_LOAD: begin
          if (abort) begin
            st      <= S_IDLE;
            dirty_q <= '0;
          end else if (commit) begin
            if (has_data) begin
              st     <= S_FLUSH;
              scan_q <= '0;
              fin_q  <= {page_q, col_q};
            end else begin
              st      <= S_IDLE;
              dirty_q <= '0;
            end
          end else if (start) begin
            page_q   <= start_addr[ADDR_W-1:COL_W];
            col_q    <= start_addr[COL_W-1:0];
            dirty_q  <= '0;
            has_data <= 1'b0;
          end else if (byte_vld) begin
            dirty_q[col_q] <= 1'b1;
            col_q          <= col_q + 1'b1;
            has_data       <= 1'b1;
          end
        end
        S_FLUSH: begin
          scan_q <= scan_q + 1'b1;
          if (scan_q == COL_W'(DEPTH - 1)) begin
            st      <= S_IDLE;
            done_q  <= 1'b1;
            dirty_q <= '0;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) data_q[col_q] <= byte_data;
  end

  assign busy       = (st == S_FLUSH);
  assign mem_we     = busy && dirty_q[scan_q];
  assign mem_addr   = {page_q, scan_q};
  assign mem_wdata  = data_q[scan_q];
  assign done       = done_q;
  assign final_addr = fin_q;

  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && col_q == '1) |=> (col_q == '0 && $stable(page_q))); // R2
  AST_ABORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && abort) |=> (!busy && !mem_we)); // R5
  AST_EMPTY_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && commit && !abort && !has_data) |=> !busy); // R5
  AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[ADDR_W-1:COL_W] == fin_q[ADDR_W-1:COL_W])); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R7
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fin_q) && $stable(page_q))); // R8
endmodule

// File: tb/tb_pgwr_buf.sv
module tb_pgwr_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, byte_vld = 1'b0, abort = 1'b0, commit = 1'b0;
  logic [7:0] start_addr = '0, byte_data = '0;
  logic       mem_we, busy, done;
  logic [7:0] mem_addr, mem_wdata, final_addr;

  int n_chk = 0, n_bad = 0, cyc = 0, trial = 0;
  logic [7:0] shadow [256];
  logic [7:0] expm   [256];
  int  wcount;
  int  last_col;
  bit  order_bad;

  pgwr_buf dut (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && mem_we) begin
      shadow[mem_addr] <= mem_wdata;
      wcount = wcount + 1;
      if (int'(mem_addr[3:0]) <= last_col) order_bad = 1'b1;
      last_col = int'(mem_addr[3:0]);
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  function automatic logic [7:0] dval(input int t, input int k);
    return 8'((t * 7 + k * 13 + 5) & 255);
  endfunction

  // mode: 0 commit, 1 abort, 2 commit with noise while busy
  task automatic run(input int page, input int c0, input int n, input int mode);
    int busy_cyc, waitc;
    bit saw_done, saw_busy;
    logic [7:0] fa;
    trial++;
    wcount = 0; last_col = -1; order_bad = 1'b0;
    @(negedge clk);
    start = 1'b1; start_addr = 8'((page << 4) | c0);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < n; k++) begin
      byte_vld = 1'b1; byte_data = dval(trial, k);
      @(negedge clk);
      byte_vld = 1'b0;
      if (k % 3 == 1) @(negedge clk);
    end
    if (mode == 1) abort = 1'b1; else commit = 1'b1;
    @(negedge clk);
    abort = 1'b0; commit = 1'b0;
    busy_cyc = 0; saw_done = 0; saw_busy = 0; fa = '0;
    for (waitc = 0; waitc < 24; waitc++) begin
      if (busy) begin
        busy_cyc++; saw_busy = 1;
        if (mode == 2 && busy_cyc == 3) begin
          start = 1'b1; start_addr = 8'h3A; byte_vld = 1'b1; byte_data = 8'hEE; abort = 1'b1;
        end else if (mode == 2 && busy_cyc == 5) begin
          commit = 1'b1; byte_vld = 1'b1;
        end else begin
          start = 1'b0; byte_vld = 1'b0; abort = 1'b0; commit = 1'b0;
        end
      end else begin
        start = 1'b0; byte_vld = 1'b0; abort = 1'b0; commit = 1'b0;
      end
      if (done) begin saw_done = 1; fa = final_addr; end
      @(negedge clk);
    end
    if (mode != 1 && n > 0) begin
      for (int k = 0; k < n; k++) expm[(page << 4) | ((c0 + k) % 16)] = dval(trial, k);
      chk(busy_cyc == 16, "R7 busy length", busy_cyc, 16);
      chk(saw_done, "R7 done pulse", saw_done, 1);
      chk(fa == 8'((page << 4) | ((c0 + n) % 16)), "R4 final_addr", fa, (page << 4) | ((c0 + n) % 16));
      chk(wcount == (n < 16 ? n : 16), "R6 write count", wcount, n < 16 ? n : 16);
      chk(!order_bad, "R6 ascending order", order_bad, 0);
    end else begin
      chk(!saw_busy && !saw_done && wcount == 0, "R5 discard", wcount, 0);
    end
    for (int a = 0; a < 256; a++)
      if (shadow[a] !== expm[a]) begin
        chk(0, (mode == 2) ? "R8 memory" : "R2/R3 memory", shadow[a], expm[a]);
        break;
      end
    n_chk++;
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin shadow[a] = '0; expm[a] = '0; end
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we, "R1 reset state", {busy, done, mem_we}, 0);
    rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7: sweep start column and count under both endings
    for (int c0 = 0; c0 < 16; c0++)
      for (int n = 0; n <= 20; n++)
        for (int m = 0; m < 2; m++)
          run((c0 + n) % 16, c0, n, m);
    // R4 the 12-from-10 case, and R8 noise while busy
    run(5, 10, 12, 0);
    for (int n = 1; n <= 18; n += 3) run(2, n % 16, n, 2);
    // R9: restart mid-load discards earlier bytes
    trial++;
    wcount = 0; last_col = -1; order_bad = 1'b0;
    @(negedge clk); start = 1'b1; start_addr = 8'h70;
    @(negedge clk); start = 1'b0; byte_vld = 1'b1; byte_data = 8'h11;
    @(negedge clk); byte_data = 8'h22;
    @(negedge clk); byte_vld = 1'b0; start = 1'b1; start_addr = 8'h7E;
    @(negedge clk); start = 1'b0; byte_vld = 1'b1; byte_data = 8'h33;
    @(negedge clk); byte_vld = 1'b0; commit = 1'b1;
    @(negedge clk); commit = 1'b0;
    repeat (20) @(negedge clk);
    expm[8'h7E] = 8'h33;
    chk(wcount == 1, "R9 restart write count", wcount, 1);
    chk(shadow[8'h70] === expm[8'h70] && shadow[8'h7E] === 8'h33, "R9 restart contents", shadow[8'h7E], 8'h33);
    chk(final_addr == 8'h7F, "R9 R4 final_addr", final_addr, 8'h7F);
    finish_run();
  end
endmodule